// File: doc/BRIEF.md
# Processor Reset Sequencer with Phase-Aligned Release

This block sits on the double-rate processor clock (clk2) and generates the processor reset. It also generates the half-rate clock whose phase the processor adopts. While power is not good, reset is held, and the half-rate clock and the sequencing state return to their starting values. Once power-good rises, reset stays high for at least the programmed number of clk2 cycles per millisecond. It also stays high for at least the fixed minimum, which is 15 cycles, or 80 cycles when self-test is wanted. Release happens only on a clk2 edge where the half-rate clock falls, so the processor's internal clock lines up with the generated one.

Around the release edge, the block drives the self-test strap line for a short window and then releases it to high impedance. That window is shown as an output-enable with a separate data level. The strap is low when self-test is wanted. A local request re-asserts reset at the next clk2 edge and restarts the hold. In that case only the fixed minimum applies. A flag rises at the latest point at which the processor's first fetch may happen. The model adds the self-test duration to that point when self-test was selected.

All control and status pins are plain levels. The block has no data streams, so no valid/ready handshake applies.

Top module: `cpu_reset_seq`

## Requirements
- R1: While pwr_good is low, cpu_reset is 1, half_clk is 0, strap_oe is 0, strap_n is 1 and fetch_ready is 0.
- R2: With selftest_en low, the number of clk2 rising edges from pwr_good rising until cpu_reset reads 0 is the smallest even number that is at least max(ms_cycles, 15, 2).
- R3: With selftest_en high, that count is the smallest even number that is at least max(ms_cycles, 80). The strap is then driven low.
- R4: When ext_rst_req is high at a clk2 edge, cpu_reset is 1 after that edge. The hold restarts from that edge, and ms_cycles is not applied, so the hold lasts the smallest even count that is at least 15 (or 80).
- R5: half_clk reads 0 right after reset starts (pwr_good low or an ext_rst_req edge). It then inverts on every clk2 edge, so it reads k mod 2 at the k-th edge after that entry.
- R6: strap_oe is 1 in the last cycle in which cpu_reset is 1 and in the first 4 cycles in which cpu_reset is 0. It is 0 at all other times. While strap_oe is 1, strap_n equals the inverse of selftest_en. Otherwise strap_n is 1.
- R7: Count the first cycle with cpu_reset at 0 as cycle 0. fetch_ready rises in cycle FETCH_LAT, or in cycle ST_CYCLES+FETCH_LAT when self-test was selected, and stays high until reset is asserted again.
- R8: fetch_ready is 0 in every cycle in which cpu_reset is 1, including right after a re-assertion by ext_rst_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate clock |
| pwr_good | input | 1 | Power good; low acts as asynchronous reset of the sequencer |
| ext_rst_req | input | 1 | Local reset request, sampled on clk2 |
| selftest_en | input | 1 | Request built-in self-test at the next release |
| ms_cycles | input | MS_W | clk2 cycles per millisecond |
| cpu_reset | output | 1 | Processor reset, active high |
| half_clk | output | 1 | Half-rate clock, phase restarted by reset |
| strap_n | output | 1 | Self-test strap level, low selects self-test |
| strap_oe | output | 1 | Strap driver enable; 0 means high impedance |
| fetch_ready | output | 1 | Latest first-fetch point has passed |

## Verification
The bench sweeps ms_cycles across both sides of the 15 and 80 minimums, including odd and even values, 0, 1 and the largest value. It does this with self-test on and off. A design that rounds the hold the wrong way, or that ignores one term of the maximum, releases one or more edges early or late. A design that releases on the wrong half-clock phase shows half_clk out of step at the release sample. The bench also re-requests reset while running and again in the middle of a hold. A design that keeps the old count, applies the millisecond wait again, or leaves fetch_ready or the strap window standing gives the wrong release edge or stale status. The strap window and the ready flag are compared sample by sample, so an off-by-one in either is caught.

// File: rtl/cpu_reset_seq_pkg.sv
package cpu_reset_seq_pkg;
  typedef enum logic [1:0] {
    SQ_HOLD = 2'd0,
    SQ_LAST = 2'd1,
    SQ_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/crs_hold_timer.sv
module crs_hold_timer #(
  parameter int unsigned MS_W      = 20,
  parameter int unsigned MIN_PLAIN = 15,
  parameter int unsigned MIN_ST    = 80
) (
  input  logic            clk2,
  input  logic            rst_n,
  input  logic            restart_i,
  input  logic            count_i,
  input  logic            ms_due_i,
  input  logic            st_i,
  input  logic [MS_W-1:0] ms_cycles_i,
  output logic            met_o
);
  localparam int unsigned CW = (MS_W + 1 > 8) ? MS_W + 1 : 8;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] floor_w;
  logic [CW-1:0] ms_w;
  logic [CW-1:0] need_w;
  logic [CW:0]   ahead_w;

  assign floor_w = st_i ? CW'(MIN_ST) : CW'(MIN_PLAIN);
  assign ms_w    = ms_due_i ? CW'(ms_cycles_i) : '0;
  assign need_w  = (ms_w > floor_w) ? ms_w : floor_w;
  assign ahead_w = {1'b0, cnt_q} + (CW+1)'(2);
  // release is taken from an even count so the next edge lands on half_clk high
  assign met_o   = ~cnt_q[0] && (ahead_w >= {1'b0, need_w});

  always_ff @(posedge clk2 or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (count_i && (cnt_q != {CW{1'b1}})) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  restart_clears_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/crs_post_timer.sv
module crs_post_timer #(
  parameter int unsigned ST_CYCLES = 1048636,
  parameter int unsigned FETCH_LAT = 450,
  parameter int unsigned STRAP_AFTER = 4
) (
  input  logic clk2,
  input  logic rst_n,
  input  logic run_i,
  input  logic st_i,
  output logic strap_win_o,
  output logic ready_o
);
  localparam int unsigned TW = $clog2(ST_CYCLES + FETCH_LAT + 1) + 1;
  localparam logic [TW-1:0] WAIT_PLAIN = TW'(FETCH_LAT);
  localparam logic [TW-1:0] WAIT_ST    = TW'(ST_CYCLES + FETCH_LAT);
  localparam logic [TW-1:0] WIN_END    = TW'(STRAP_AFTER);

  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] wait_w;

  assign wait_w      = st_i ? WAIT_ST : WAIT_PLAIN;
  assign strap_win_o = run_i && (tcnt_q < WIN_END);
  assign ready_o     = run_i && (tcnt_q >= wait_w);

  always_ff @(posedge clk2 or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else if (!run_i) begin
      tcnt_q <= '0;
    end else if (tcnt_q < wait_w) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  // R7
  ready_sticky_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    (ready_o && run_i) |=> (ready_o || !run_i));

  // R8
  ready_needs_run_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    ready_o |-> run_i);
endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import cpu_reset_seq_pkg::*;
#(
  parameter int unsigned MS_W      = 20,
  parameter int unsigned MIN_PLAIN = 15,
  parameter int unsigned MIN_ST    = 80,
  parameter int unsigned ST_CYCLES = 1048636,
  parameter int unsigned FETCH_LAT = 450
) (
  input  logic            clk2,
  input  logic            pwr_good,
  input  logic            ext_rst_req,
  input  logic            selftest_en,
  input  logic [MS_W-1:0] ms_cycles,
  output logic            cpu_reset,
  output logic            half_clk,
  output logic            strap_n,
  output logic            strap_oe,
  output logic            fetch_ready
);
  localparam int unsigned STRAP_AFTER = 4;

  seq_state_t state_q;
  logic       half_q;
  logic       ms_due_q;
  logic       st_lat_q;
  logic       met_w;
  logic       strap_win_w;
  logic       run_w;

  assign run_w = (state_q == SQ_RUN);

  crs_hold_timer #(
    .MS_W(MS_W), .MIN_PLAIN(MIN_PLAIN), .MIN_ST(MIN_ST)
  ) u_hold (
    .clk2(clk2), .rst_n(pwr_good), .restart_i(ext_rst_req),
    .count_i(state_q == SQ_HOLD), .ms_due_i(ms_due_q), .st_i(selftest_en),
    .ms_cycles_i(ms_cycles), .met_o(met_w)
  );

  crs_post_timer #(
    .ST_CYCLES(ST_CYCLES), .FETCH_LAT(FETCH_LAT), .STRAP_AFTER(STRAP_AFTER)
  ) u_post (
    .clk2(clk2), .rst_n(pwr_good), .run_i(run_w), .st_i(st_lat_q),
    .strap_win_o(strap_win_w), .ready_o(fetch_ready)
  );

  always_ff @(posedge clk2 or negedge pwr_good) begin
    if (!pwr_good) begin
      state_q  <= SQ_HOLD;
      half_q   <= 1'b0;
      ms_due_q <= 1'b1;
      st_lat_q <= 1'b0;
    end else if (ext_rst_req) begin
      state_q <= SQ_HOLD;
      half_q  <= 1'b0;
    end else begin
      half_q <= ~half_q;
      unique case (state_q)
        SQ_HOLD: if (met_w) begin
          state_q  <= SQ_LAST;
          st_lat_q <= selftest_en;
        end
        SQ_LAST: begin
          state_q  <= SQ_RUN;
          ms_due_q <= 1'b0;
        end
        default: state_q <= SQ_RUN;
      endcase
    end
  end

  assign cpu_reset = ~run_w;
  assign half_clk  = half_q;
  assign strap_oe  = (state_q == SQ_LAST) || strap_win_w;
  assign strap_n   = strap_oe ? ~st_lat_q : 1'b1;

  // R4
  req_reasserts_chk: assert property (@(posedge clk2) disable iff (!pwr_good)
    ext_rst_req |=> cpu_reset);

  // R5
  half_toggle_chk: assert property (@(posedge clk2) disable iff (!pwr_good)
    !ext_rst_req |=> (half_clk != $past(half_clk)));

  // R5
  release_phase_chk: assert property (@(posedge clk2) disable iff (!pwr_good)
    $fell(cpu_reset) |-> ($past(half_clk) && !half_clk));

  // R6
  strap_around_release_chk: assert property (@(posedge clk2) disable iff (!pwr_good)
    $fell(cpu_reset) |-> ($past(strap_oe) && strap_oe));
endmodule

// File: tb/cpu_reset_seq_test.sv
module cpu_reset_seq_test;
  localparam int MS_W = 8;
  localparam int ST_C = 40;
  localparam int F_L  = 12;

  logic clk2 = 1'b0;
  logic pwr_good = 1'b0;
  logic ext_rst_req = 1'b0;
  logic selftest_en = 1'b0;
  logic [MS_W-1:0] ms_cycles = '0;
  logic cpu_reset, half_clk, strap_n, strap_oe, fetch_ready;

  int checks = 0;
  int errors = 0;

  always #10 clk2 = ~clk2;

  cpu_reset_seq #(
    .MS_W(MS_W), .MIN_PLAIN(15), .MIN_ST(80), .ST_CYCLES(ST_C), .FETCH_LAT(F_L)
  ) uut (
    .clk2(clk2), .pwr_good(pwr_good), .ext_rst_req(ext_rst_req),
    .selftest_en(selftest_en), .ms_cycles(ms_cycles), .cpu_reset(cpu_reset),
    .half_clk(half_clk), .strap_n(strap_n), .strap_oe(strap_oe),
    .fetch_ready(fetch_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // sample k=0 is the current negedge, right after reset entry
  task automatic measure(input int ms_used, input bit st, input string hold_tag);
    int req, c2, wt, d;
    bit e_rst, e_oe, e_sn, e_rdy;
    req = st ? 80 : 15;
    if (ms_used > req) req = ms_used;
    if (req < 2) req = 2;
    c2 = ((req + 1) / 2) * 2;
    wt = st ? ST_C + F_L : F_L;
    for (int k = 0; k <= c2 + wt + 2; k++) begin
      if (k > 0) begin
        @(posedge clk2);
        @(negedge clk2);
      end
      d = k - c2;
      e_rst = (k < c2);
      e_oe  = (d >= -1) && (d <= 3);
      e_sn  = e_oe ? !st : 1'b1;
      e_rdy = (d >= wt);
      chk(cpu_reset == e_rst, hold_tag, cpu_reset, e_rst);
      chk(half_clk == k[0], "R5", half_clk, k[0]);
      chk(strap_oe == e_oe, "R6", strap_oe, e_oe);
      chk(strap_n == e_sn, st ? "R3" : "R6", strap_n, e_sn);
      chk(fetch_ready == e_rdy, e_rst ? "R8" : "R7", fetch_ready, e_rdy);
    end
  endtask

  task automatic power_run(input int ms, input bit st);
    @(negedge clk2);
    pwr_good = 1'b0;
    @(negedge clk2);
    // R1
    chk(cpu_reset == 1'b1, "R1", cpu_reset, 1);
    chk(half_clk == 1'b0, "R1", half_clk, 0);
    chk(strap_oe == 1'b0, "R1", strap_oe, 0);
    chk(strap_n == 1'b1, "R1", strap_n, 1);
    chk(fetch_ready == 1'b0, "R1", fetch_ready, 0);
    ms_cycles = MS_W'(ms);
    selftest_en = st;
    @(negedge clk2);
    pwr_good = 1'b1;
    measure(ms, st, st ? "R3" : "R2");
  endtask

  task automatic pulse_ext();
    @(negedge clk2);
    ext_rst_req = 1'b1;
    @(posedge clk2);
    @(negedge clk2);
    ext_rst_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk2);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int msv[12] = '{0, 1, 2, 14, 15, 16, 17, 79, 80, 81, 150, 255};
    repeat (3) @(negedge clk2);
    for (int s = 0; s < 2; s++) begin
      foreach (msv[i]) power_run(msv[i], s[0]);
    end
    // R4: request while running, ms_cycles left large to show it is not applied
    for (int s = 0; s < 2; s++) begin
      power_run(200, s[0]);
      pulse_ext();
      measure(0, s[0], "R4");
      pulse_ext();
      repeat (5) @(negedge clk2);
      pulse_ext();
      measure(0, s[0], "R4");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule